// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

The router takes a vector of already-synchronized pin inputs and steers any one of them onto each of its interrupt channels. Every channel has its own pin selector, a choice between level and edge detection, a polarity bit that turns a low-active source into a high-active event, and a stability filter that rejects short glitches. All outputs are active-high, so the interrupt controller downstream never needs to know how a pin is wired.

Software configures the block over a simple 32-bit register port with a single-cycle write strobe and a combinational read path. Pin selectors are packed four to a word. One word holds the detection-mode and polarity bits and another holds the filter lengths. A pending word reports the sticky edge flags and clears them when 1s are written to it. When software rebinds a channel to another pin, or changes its mode or polarity, the channel's edge history is dropped, so the change never fakes an interrupt.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register reads 0: all channels route pin 0, use level mode and active-high sense, and have the filter bypassed. No edge is pending and `irq_o` is 0.
- R2: Register map at `cfg_addr`:
  - Addresses 0 and 1 hold the pin selectors. Channel i uses word i/4, bits [8*(i%4)+7 : 8*(i%4)].
  - Address 2 holds the mode bits. Bit i = 1 puts channel i in edge mode, and bit i+16 = 1 makes it active-low. The other bits read 0.
  - Address 3 holds the filter lengths. Channel i uses bits [4i+3:4i].
  - Reading address 4 returns the pending bits in [7:0].
  - A register written and then read returns the stored value.
- R3: Channel i observes only `pins_i[sel_i]`. Changes on other pins do not affect it, and pin 255 can be selected.
- R4: In level mode with the filter bypassed, `irq_o[i]` equals the polarity-corrected selected pin one clock after the pin changes.
- R5: An active-low channel treats a low pin as asserted. In level mode a low pin drives `irq_o` high. In edge mode a falling pin edge is reported.
- R6: In edge mode, a rising edge of the polarity-corrected, filtered input sets a sticky pending bit. `irq_o` rises two clocks after the pin changes and stays high after the pin returns to its idle level.
- R7: Writing address 4 clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R8: With a filter length N ≥ 1, a new input value passes only after it has differed from the current filtered value on N consecutive clocks. A shorter pulse is dropped. N = 0 bypasses the filter and behaves like N = 1.
- R9: A write that changes a channel's selector, mode bit or polarity bit has these effects on that channel:
  - It clears the channel's pending bit.
  - It reloads the channel's filter from the newly selected input.
  - It produces no edge from the change itself.
  - Later, genuine edges are still detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| pins_i | input | 256 | Synchronized pin inputs |
| irq_o | output | 8 | Active-high interrupt per channel |

## Verification
With the filter bypassed, a level-mode channel's output changes one clock after the pin changes. An edge-mode channel's pending bit needs a second clock, and a filter of length N delays the level result to N clocks. A write takes effect on the clock that accepts it; a pending clear is therefore visible at once, while the history reload and the pending drop that follow a configuration change land one clock later. The bench drives inputs and samples outputs on the falling edge, and it checks each result in the cycle where it is due and, where the requirement says so, also one cycle earlier, where the output must still be unchanged. After every configuration write the bench waits three clocks before applying pin stimulus, so reload effects never mix with the behaviour under test.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int FILT_W  = 4;
  localparam int POL_OFS = 16;

  // Number of register words needed to hold all pin selectors.
  function automatic int sel_words(input int n_ch, input int sel_w);
    return (n_ch * sel_w + DATA_W - 1) / DATA_W;
  endfunction
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  input  logic [NUM_CH-1:0]          pend_i,
  output logic [NUM_CH*SEL_W-1:0]    sel_o,
  output logic [NUM_CH-1:0]          edge_en_o,
  output logic [NUM_CH-1:0]          act_low_o,
  output logic [NUM_CH*FILT_W-1:0]   filt_o,
  output logic [NUM_CH-1:0]          clr_o,
  output logic [NUM_CH-1:0]          chg_o
);
  localparam int SEL_WORDS = sel_words(NUM_CH, SEL_W);
  localparam int SEL_BITS  = SEL_WORDS * DATA_W;
  localparam int A_MODE    = SEL_WORDS;
  localparam int A_FILT    = SEL_WORDS + 1;
  localparam int A_PEND    = SEL_WORDS + 2;

  logic [SEL_BITS-1:0]      sel_q, sel_d;
  logic [NUM_CH-1:0]        edge_q, edge_d, low_q, low_d, chg_q, chg_d;
  logic [NUM_CH*FILT_W-1:0] filt_q, filt_d;

  // A channel's history must be dropped when anything that shapes its input changes.
  function automatic logic cfg_moved(input logic [SEL_W-1:0] s_old, input logic [SEL_W-1:0] s_new,
                                     input logic e_old, input logic e_new,
                                     input logic l_old, input logic l_new);
    return (s_old != s_new) || (e_old != e_new) || (l_old != l_new);
  endfunction

  always_comb begin
    sel_d  = sel_q;
    edge_d = edge_q;
    low_d  = low_q;
    filt_d = filt_q;
    clr_o  = '0;
    if (we) begin
      for (int k = 0; k < SEL_WORDS; k++) begin
        if (addr == ADDR_W'(k)) sel_d[k*DATA_W +: DATA_W] = wdata;
      end
      if (addr == ADDR_W'(A_MODE)) begin
        edge_d = wdata[NUM_CH-1:0];
        low_d  = wdata[POL_OFS +: NUM_CH];
      end
      if (addr == ADDR_W'(A_FILT)) filt_d = wdata[NUM_CH*FILT_W-1:0];
      if (addr == ADDR_W'(A_PEND)) clr_o  = wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      chg_d[i] = cfg_moved(sel_q[i*SEL_W +: SEL_W], sel_d[i*SEL_W +: SEL_W],
                           edge_q[i], edge_d[i], low_q[i], low_d[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      edge_q <= '0;
      low_q  <= '0;
      filt_q <= '0;
      chg_q  <= '0;
    end else begin
      sel_q  <= sel_d;
      edge_q <= edge_d;
      low_q  <= low_d;
      filt_q <= filt_d;
      chg_q  <= chg_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < SEL_WORDS; k++) begin
      if (addr == ADDR_W'(k)) rdata = sel_q[k*DATA_W +: DATA_W];
    end
    if (addr == ADDR_W'(A_MODE)) begin
      rdata[NUM_CH-1:0]         = edge_q;
      rdata[POL_OFS +: NUM_CH]  = low_q;
    end
    if (addr == ADDR_W'(A_FILT)) rdata[NUM_CH*FILT_W-1:0] = filt_q;
    if (addr == ADDR_W'(A_PEND)) rdata[NUM_CH-1:0]        = pend_i;
  end

  assign sel_o     = sel_q[NUM_CH*SEL_W-1:0];
  assign edge_en_o = edge_q;
  assign act_low_o = low_q;
  assign filt_o    = filt_q;
  assign chg_o     = chg_q;
endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              act_low_i,
  input  logic              edge_en_i,
  input  logic [FILT_W-1:0] filt_n_i,
  input  logic              chg_i,
  input  logic              clr_i,
  output logic              norm_o,
  output logic              filt_o,
  output logic              edge_o,
  output logic              pend_o,
  output logic              irq_o
);
  logic              filt_q, prev_q, arm_q, pend_q;
  logic [FILT_W-1:0] cnt_q;

  // True when this differing sample completes the run of N; N of 0 or 1 passes at once.
  function automatic logic filt_release(input logic [FILT_W-1:0] cnt, input logic [FILT_W-1:0] n);
    return ({1'b0, cnt} + 1'b1) >= {1'b0, n};
  endfunction

  assign norm_o = pin_i ^ act_low_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (chg_i || norm_o == filt_q) begin
      filt_q <= norm_o;
      cnt_q  <= '0;
    end else if (filt_release(cnt_q, filt_n_i)) begin
      filt_q <= norm_o;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      prev_q <= filt_q;
      arm_q  <= !chg_i;
    end
  end

  assign edge_o = filt_q & ~prev_q & arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pend_q <= 1'b0;
    else if (chg_i)                 pend_q <= 1'b0;
    else if (edge_en_i && edge_o)   pend_q <= 1'b1;
    else if (clr_i)                 pend_q <= 1'b0;
  end

  assign filt_o = filt_q;
  assign pend_o = pend_q;
  assign irq_o  = edge_en_i ? pend_q : filt_q;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_PINS = 256,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_CH-1:0]   irq_o
);
  localparam int SEL_W = $clog2(NUM_PINS);

  logic [NUM_CH*SEL_W-1:0]  sel_flat;
  logic [NUM_CH*FILT_W-1:0] filt_flat;
  logic [NUM_CH-1:0]        edge_en, act_low, clr_pulse, chg_pulse;
  logic [NUM_CH-1:0]        ch_pin, ch_norm, ch_filt, ch_edge, ch_pend;

  gpio_irq_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .pend_i(ch_pend), .sel_o(sel_flat), .edge_en_o(edge_en), .act_low_o(act_low),
    .filt_o(filt_flat), .clr_o(clr_pulse), .chg_o(chg_pulse)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_pin[g] = pins_i[sel_flat[g*SEL_W +: SEL_W]];
    gpio_irq_chan #(.FILT_W(FILT_W)) u_chan (
      .clk, .rst_n, .pin_i(ch_pin[g]), .act_low_i(act_low[g]), .edge_en_i(edge_en[g]),
      .filt_n_i(filt_flat[g*FILT_W +: FILT_W]), .chg_i(chg_pulse[g]), .clr_i(clr_pulse[g]),
      .norm_o(ch_norm[g]), .filt_o(ch_filt[g]), .edge_o(ch_edge[g]), .pend_o(ch_pend[g]),
      .irq_o(irq_o[g])
    );
  end
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk #(
  parameter int NUM_CH = 8,
  parameter int FILT_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CH-1:0]        edge_en,
  input logic [NUM_CH-1:0]        clr_pulse,
  input logic [NUM_CH-1:0]        chg_pulse,
  input logic [NUM_CH-1:0]        ch_norm,
  input logic [NUM_CH-1:0]        ch_edge,
  input logic [NUM_CH-1:0]        ch_pend,
  input logic [NUM_CH*FILT_W-1:0] filt_flat,
  input logic [NUM_CH-1:0]        irq_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_a
    // R6: pending only rises on a detected edge in edge mode
    a_r6_pend_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_pend[g] && !(ch_edge[g] && edge_en[g])) |=> !ch_pend[g]);
    // R6: pending is sticky
    a_r6_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_pend[g] && !clr_pulse[g] && !chg_pulse[g]) |=> ch_pend[g]);
    // R7: write-1 clear takes effect when no new edge competes
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse[g] && !(ch_edge[g] && edge_en[g])) |=> !ch_pend[g]);
    // R9: a configuration change never yields an edge
    a_r9_no_false_edge: assert property (@(posedge clk) disable iff (!rst_n)
      chg_pulse[g] |=> !ch_edge[g]);
    // R4: bypassed level channel follows the corrected pin one clock later
    a_r4_level_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_flat[g*FILT_W +: FILT_W] == '0) |=> (edge_en[g] || irq_o[g] == $past(ch_norm[g])));
  end
endmodule

bind gpio_irq_router gpio_irq_router_chk #(.NUM_CH(NUM_CH), .FILT_W(gpio_irq_pkg::FILT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_en(edge_en), .clr_pulse(clr_pulse), .chg_pulse(chg_pulse),
  .ch_norm(ch_norm), .ch_edge(ch_edge), .ch_pend(ch_pend), .filt_flat(filt_flat), .irq_o(irq_o)
);

// File: tb/test_gpio_irq_router.sv
module test_gpio_irq_router;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic [255:0] pins = '0;
  logic [7:0]   irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_router i_gpio_irq_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pins_i(pins), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 32'h0);
    end
    chk("R1 reset irq", {24'h0, irq}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(3'd0, 32'h0403_0201); rd(3'd0, d); chk("R2 sel word0", d, 32'h0403_0201);
    wr(3'd1, 32'hFF0A_0908); rd(3'd1, d); chk("R2 sel word1", d, 32'hFF0A_0908);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, d); chk("R2 mode unused bits", d, 32'h00FF_00FF);
    wr(3'd3, 32'h7654_3210); rd(3'd3, d); chk("R2 filter word", d, 32'h7654_3210);
    wr(3'd0, 0); wr(3'd1, 0); wr(3'd2, 0); wr(3'd3, 0);
    tick(3);
    rd(3'd4, d); chk("R2 pending read", d, 32'h0);
  endtask

  task automatic t_level;
    wr(3'd0, 32'h0000_0005);            // ch0 -> pin 5
    wr(3'd1, 32'h0000_FF00);            // ch5 (word1 bits 15:8) -> pin 255
    tick(3);
    pins[5] = 1'b1; tick(1);
    chk("R4 level rise one clock", {31'h0, irq[0]}, 32'h1);
    pins[6] = 1'b1; pins[5] = 1'b0; tick(1);
    chk("R3 other pin ignored, R4 fall", {31'h0, irq[0]}, 32'h0);
    pins[6] = 1'b0;
    pins[255] = 1'b1; tick(1);
    chk("R3 pin 255 on ch5", {30'h0, irq[5], irq[4]}, 32'h2);
    pins[255] = 1'b0; tick(1);
  endtask

  task automatic t_pol;
    wr(3'd2, 32'h0002_0000);            // ch1 active-low, pin 0
    tick(3);
    chk("R5 low pin asserts", {31'h0, irq[1]}, 32'h1);
    pins[0] = 1'b1; tick(1);
    chk("R5 high pin deasserts", {31'h0, irq[1]}, 32'h0);
    pins[0] = 1'b0; tick(1);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(3'd0, 32'h0010_0005);            // ch2 -> pin 16
    wr(3'd2, 32'h0000_0004);            // ch2 edge, active-high
    tick(3);
    pins[16] = 1'b1; tick(1);
    chk("R6 not yet after one clock", {31'h0, irq[2]}, 32'h0);
    tick(1);
    chk("R6 pending after two clocks", {31'h0, irq[2]}, 32'h1);
    pins[16] = 1'b0; tick(3);
    chk("R6 sticky", {31'h0, irq[2]}, 32'h1);
    rd(3'd4, d); chk("R6 pending readback", d, 32'h4);
    wr(3'd4, 32'h0); tick(1);
    chk("R7 zero write keeps pending", {31'h0, irq[2]}, 32'h1);
    wr(3'd4, 32'h4);
    chk("R7 clear", {31'h0, irq[2]}, 32'h0);
    wr(3'd2, 32'h0004_0004);            // active-low edge; pin is low so input now asserted
    tick(3);
    chk("R9 polarity change no false edge", {31'h0, irq[2]}, 32'h0);
    pins[16] = 1'b1; tick(2);
    chk("R5 rising pin ignored when low-active", {31'h0, irq[2]}, 32'h0);
    pins[16] = 1'b0; tick(2);
    chk("R5 falling pin edge reported", {31'h0, irq[2]}, 32'h1);
    wr(3'd4, 32'h4);
  endtask

  task automatic t_filter;
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h0000_0003);            // ch0 filter N=3
    tick(3);
    pins[5] = 1'b1; tick(2);
    chk("R8 held back before N", {31'h0, irq[0]}, 32'h0);
    tick(1);
    chk("R8 passed after N", {31'h0, irq[0]}, 32'h1);
    pins[5] = 1'b0; tick(2);
    pins[5] = 1'b1; tick(3);
    chk("R8 short pulse dropped", {31'h0, irq[0]}, 32'h1);
    pins[5] = 1'b0; tick(3);
    chk("R8 long low passed", {31'h0, irq[0]}, 32'h0);
    wr(3'd3, 32'h0);
    tick(2);
  endtask

  task automatic t_hist;
    logic [31:0] d;
    wr(3'd0, 32'h0A10_0005);            // ch3 -> pin 10
    wr(3'd2, 32'h0000_0008);            // ch3 edge
    tick(3);
    pins[20] = 1'b1;
    wr(3'd0, 32'h1410_0005);            // ch3 -> pin 20, already high
    tick(4);
    chk("R9 rebind no false edge", {31'h0, irq[3]}, 32'h0);
    rd(3'd4, d); chk("R9 no pending after rebind", d, 32'h0);
    pins[20] = 1'b0; tick(2);
    pins[20] = 1'b1; tick(2);
    chk("R9 real edge after rebind", {31'h0, irq[3]}, 32'h1);
    wr(3'd0, 32'h0A10_0005);
    tick(2);
    chk("R9 rebind drops pending", {31'h0, irq[3]}, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_regs();
    t_level();
    t_pol();
    t_edge();
    t_filter();
    t_hist();
    finish_run();
  end
endmodule